// File: doc/BRIEF.md
# 8x8 Pattern Expansion Unit

This unit supplies the pattern colour for one destination pixel of a block-transfer engine. It can also tell the pixel pipeline to leave that pixel unwritten. The pattern is an 8x8 tile held in byte-wide memory. The pixel position wraps onto the tile in both axes. The row is the vertical alignment plus y, modulo 8. The column is the low three destination-address bits plus x, modulo 8.

There are two pattern modes:

- **Monochrome mode.** Each tile row is one byte. The selected bit picks the foreground or background colour, and the result is trimmed to the pixel's byte width. A transparency option asks the pipeline to skip pixels whose bit is clear. A solid-fill option treats every bit as zero, so the unit answers without touching memory.
- **Colour mode at one byte per pixel.** The tile is 64 bytes, row by row, and the addressed byte is the colour.

A request is accepted for one cycle while the unit is idle. The unit then issues at most one memory read and pulses a result valid once the answer is ready. Combining the result with source or destination data is left to the next stage.

Top module: `pat_expand`

## Requirements
- R1: After reset `busy_o`, `mem_rd_o` and `res_valid_o` are low.
- R2: In monochrome mode (control bit 18 = 1) without solid fill, the cycle after acceptance drives `mem_rd_o` high for exactly one cycle. In that cycle `mem_addr_o` = base + ((valign + y) mod 8).
- R3: In colour mode (control bit 18 = 0) with `bpp_i` = 0 (one byte per pixel), the single read goes to base + 8*((valign + y) mod 8) + ((dst_lo + x) mod 8).
- R4: In monochrome mode the bit index is (dst_lo + x) mod 8, with index 0 being the byte's least significant bit. A 1 bit returns the foreground colour and a 0 bit returns the background colour.
- R5: `res_skip_o` is 1 only in monochrome mode, and only when the selected bit is 0 and control bit 17 is 1. With bit 17 clear the pixel is never skipped.
- R6: Monochrome colours are masked to the low 8*(`bpp_i`+1) bits, where `bpp_i` = 0..3 encodes 1..4 bytes per pixel.
- R7: Solid fill is monochrome mode with control bit 19 = 1. It issues no read, returns the masked background colour with `res_valid_o` two cycles after acceptance, and skips the pixel when bit 17 is set.
- R8: In colour mode with `bpp_i` = 0, the colour is the read byte zero-extended and the pixel is never skipped. Control bits 17 and 19 have no effect there.
- R9: In colour mode with `bpp_i` ≠ 0, no read is made. The masked background colour is returned with `res_valid_o` two cycles after acceptance, and the pixel is not skipped.
- R10: `res_valid_o` is a single-cycle pulse. It appears in the cycle after `mem_rvalid_i` is sampled high.
- R11: Requests presented while `busy_o` is high are ignored. They cause no read and no result, and they do not alter the pending answer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Pixel request, taken when idle |
| ctl_i | input | 32 | Control word (bits 17 transparent, 18 monochrome, 19 solid) |
| pat_base_i | input | ADDR_W | Pattern tile base address |
| dst_lo_i | input | 3 | Destination address bits 2:0 |
| valign_i | input | 3 | Vertical pattern alignment |
| x_i | input | COORD_W | Pixel x position |
| y_i | input | COORD_W | Pixel y position |
| fg_i | input | 8*COLOR_BYTES | Foreground colour |
| bg_i | input | 8*COLOR_BYTES | Background colour |
| bpp_i | input | log2(COLOR_BYTES) | Bytes per pixel minus one |
| busy_o | output | 1 | Request in progress |
| mem_rd_o | output | 1 | Pattern memory read strobe |
| mem_addr_o | output | ADDR_W | Pattern memory byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data byte |
| res_valid_o | output | 1 | Result pulse |
| res_color_o | output | 8*COLOR_BYTES | Pattern colour |
| res_skip_o | output | 1 | Pixel must not be written |

## Verification
The properties rely on the memory answering each read with exactly one `mem_rvalid_i` pulse. That pulse must come at least one cycle after the strobe. They also rely on `mem_rvalid_i` staying low whenever no read is outstanding. The bench keeps to this by driving `mem_rvalid_i` only from its request task. The task waits one to three cycles after it sees the strobe, then raises the pulse for one cycle. Requests made during a busy period never get a data response, so the ignore property is observed without breaking that assumption.

// File: rtl/pat_expand_pkg.sv
package pat_expand_pkg;

    localparam int CTL_W       = 32;
    localparam int CTL_TRANSP  = 17;
    localparam int CTL_MONO    = 18;
    localparam int CTL_SOLID   = 19;
    localparam int PAT_LG      = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FAST  = 2'd3
    } pe_state_e;

endpackage

// File: rtl/pat_addr_gen.sv
module pat_addr_gen #(
    parameter int ADDR_W  = 24,
    parameter int COORD_W = 12
) (
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [2:0]         dst_lo_i,
    input  logic [2:0]         valign_i,
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  logic               mono_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [2:0]         col_o
);
    import pat_expand_pkg::*;

    localparam int OFS_W = 2 * PAT_LG;

    logic [PAT_LG-1:0] row;
    logic [PAT_LG-1:0] col;
    logic [OFS_W-1:0]  tile_ofs;

    always_comb begin
        row      = valign_i + y_i[PAT_LG-1:0];
        col      = dst_lo_i + x_i[PAT_LG-1:0];
        tile_ofs = mono_i ? {{PAT_LG{1'b0}}, row} : {row, col};
        addr_o   = base_i + ADDR_W'(tile_ofs);
        col_o    = col;
    end

endmodule

// File: rtl/pat_color_sel.sv
module pat_color_sel #(
    parameter int COLOR_BYTES = 4,
    localparam int COLOR_W    = 8 * COLOR_BYTES,
    localparam int BPP_W      = $clog2(COLOR_BYTES)
) (
    input  logic [7:0]         byte_i,
    input  logic               mono_i,
    input  logic               solid_i,
    input  logic               transp_i,
    input  logic [BPP_W-1:0]   bpp_i,
    input  logic [2:0]         col_i,
    input  logic [COLOR_W-1:0] fg_i,
    input  logic [COLOR_W-1:0] bg_i,
    output logic [COLOR_W-1:0] color_o,
    output logic               skip_o
);

    logic [COLOR_W-1:0] lane_mask;
    logic               pat_bit;

    for (genvar i = 0; i < COLOR_BYTES; i++) begin : g_lane
        assign lane_mask[8*i +: 8] = (32'(bpp_i) >= i) ? 8'hFF : 8'h00;
    end

    always_comb begin
        pat_bit = solid_i ? 1'b0 : byte_i[col_i];
        color_o = '0;
        skip_o  = 1'b0;
        if (mono_i) begin
            color_o = (pat_bit ? fg_i : bg_i) & lane_mask;
            skip_o  = transp_i & ~pat_bit;
        end else if (bpp_i == '0) begin
            color_o = COLOR_W'(byte_i);
        end else begin
            color_o = bg_i & lane_mask;
        end
    end

endmodule

// File: rtl/pat_seq.sv
module pat_seq #(
    parameter int ADDR_W      = 24,
    parameter int COLOR_BYTES = 4,
    localparam int COLOR_W    = 8 * COLOR_BYTES,
    localparam int BPP_W      = $clog2(COLOR_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic               mono_i,
    input  logic               solid_i,
    input  logic               transp_i,
    input  logic [BPP_W-1:0]   bpp_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [2:0]         col_i,
    input  logic [COLOR_W-1:0] fg_i,
    input  logic [COLOR_W-1:0] bg_i,
    input  logic               mem_rvalid_i,
    input  logic [7:0]         mem_rdata_i,
    input  logic [COLOR_W-1:0] sel_color_i,
    input  logic               sel_skip_i,
    output logic [7:0]         sel_byte_o,
    output logic               sel_mono_o,
    output logic               sel_solid_o,
    output logic               sel_transp_o,
    output logic [BPP_W-1:0]   sel_bpp_o,
    output logic [2:0]         sel_col_o,
    output logic [COLOR_W-1:0] sel_fg_o,
    output logic [COLOR_W-1:0] sel_bg_o,
    output logic               busy_o,
    output logic               mem_rd_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic               res_valid_o,
    output logic [COLOR_W-1:0] res_color_o,
    output logic               res_skip_o
);
    import pat_expand_pkg::*;

    typedef struct packed {
        pe_state_e          st;
        logic               mono;
        logic               solid;
        logic               transp;
        logic [BPP_W-1:0]   bpp;
        logic [ADDR_W-1:0]  addr;
        logic [2:0]         col;
        logic [COLOR_W-1:0] fg;
        logic [COLOR_W-1:0] bg;
        logic               res_valid;
        logic [COLOR_W-1:0] res_color;
        logic               res_skip;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.res_valid = 1'b0;
        s_d.res_skip  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    s_d.mono   = mono_i;
                    s_d.solid  = solid_i;
                    s_d.transp = transp_i;
                    s_d.bpp    = bpp_i;
                    s_d.addr   = addr_i;
                    s_d.col    = col_i;
                    s_d.fg     = fg_i;
                    s_d.bg     = bg_i;
                    if ((mono_i && solid_i) || (!mono_i && bpp_i != '0))
                        s_d.st = ST_FAST;
                    else
                        s_d.st = ST_ISSUE;
                end
            end
            ST_ISSUE: s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    s_d.res_valid = 1'b1;
                    s_d.res_color = sel_color_i;
                    s_d.res_skip  = sel_skip_i;
                    s_d.st        = ST_IDLE;
                end
            end
            ST_FAST: begin
                s_d.res_valid = 1'b1;
                s_d.res_color = sel_color_i;
                s_d.res_skip  = sel_skip_i;
                s_d.st        = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_byte_o   = (s_q.st == ST_WAIT) ? mem_rdata_i : 8'h00;
    assign sel_mono_o   = s_q.mono;
    assign sel_solid_o  = s_q.solid;
    assign sel_transp_o = s_q.transp;
    assign sel_bpp_o    = s_q.bpp;
    assign sel_col_o    = s_q.col;
    assign sel_fg_o     = s_q.fg;
    assign sel_bg_o     = s_q.bg;
    assign busy_o       = (s_q.st != ST_IDLE);
    assign mem_rd_o     = (s_q.st == ST_ISSUE);
    assign mem_addr_o   = s_q.addr;
    assign res_valid_o  = s_q.res_valid;
    assign res_color_o  = s_q.res_color;
    assign res_skip_o   = s_q.res_skip;

endmodule

// File: rtl/pat_expand.sv
module pat_expand #(
    parameter int ADDR_W      = 24,
    parameter int COORD_W     = 12,
    parameter int COLOR_BYTES = 4,
    localparam int COLOR_W    = 8 * COLOR_BYTES,
    localparam int BPP_W      = $clog2(COLOR_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic [31:0]        ctl_i,
    input  logic [ADDR_W-1:0]  pat_base_i,
    input  logic [2:0]         dst_lo_i,
    input  logic [2:0]         valign_i,
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  logic [COLOR_W-1:0] fg_i,
    input  logic [COLOR_W-1:0] bg_i,
    input  logic [BPP_W-1:0]   bpp_i,
    output logic               busy_o,
    output logic               mem_rd_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    input  logic               mem_rvalid_i,
    input  logic [7:0]         mem_rdata_i,
    output logic               res_valid_o,
    output logic [COLOR_W-1:0] res_color_o,
    output logic               res_skip_o
);
    import pat_expand_pkg::*;

    logic [ADDR_W-1:0]  req_addr;
    logic [2:0]         req_col;
    logic [7:0]         sel_byte;
    logic               sel_mono, sel_solid, sel_transp;
    logic [BPP_W-1:0]   sel_bpp;
    logic [2:0]         sel_col;
    logic [COLOR_W-1:0] sel_fg, sel_bg, sel_color;
    logic               sel_skip;

    pat_addr_gen #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_addr (
        .base_i   (pat_base_i),
        .dst_lo_i (dst_lo_i),
        .valign_i (valign_i),
        .x_i      (x_i),
        .y_i      (y_i),
        .mono_i   (ctl_i[CTL_MONO]),
        .addr_o   (req_addr),
        .col_o    (req_col)
    );

    pat_seq #(.ADDR_W(ADDR_W), .COLOR_BYTES(COLOR_BYTES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .mono_i       (ctl_i[CTL_MONO]),
        .solid_i      (ctl_i[CTL_SOLID]),
        .transp_i     (ctl_i[CTL_TRANSP]),
        .bpp_i        (bpp_i),
        .addr_i       (req_addr),
        .col_i        (req_col),
        .fg_i         (fg_i),
        .bg_i         (bg_i),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .sel_color_i  (sel_color),
        .sel_skip_i   (sel_skip),
        .sel_byte_o   (sel_byte),
        .sel_mono_o   (sel_mono),
        .sel_solid_o  (sel_solid),
        .sel_transp_o (sel_transp),
        .sel_bpp_o    (sel_bpp),
        .sel_col_o    (sel_col),
        .sel_fg_o     (sel_fg),
        .sel_bg_o     (sel_bg),
        .busy_o       (busy_o),
        .mem_rd_o     (mem_rd_o),
        .mem_addr_o   (mem_addr_o),
        .res_valid_o  (res_valid_o),
        .res_color_o  (res_color_o),
        .res_skip_o   (res_skip_o)
    );

    pat_color_sel #(.COLOR_BYTES(COLOR_BYTES)) u_sel (
        .byte_i   (sel_byte),
        .mono_i   (sel_mono),
        .solid_i  (sel_solid),
        .transp_i (sel_transp),
        .bpp_i    (sel_bpp),
        .col_i    (sel_col),
        .fg_i     (sel_fg),
        .bg_i     (sel_bg),
        .color_o  (sel_color),
        .skip_o   (sel_skip)
    );

endmodule

// File: rtl/pat_expand_chk.sv
module pat_expand_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic [31:0]       ctl_i,
    input logic [ADDR_W-1:0] pat_base_i,
    input logic              busy_o,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rvalid_i,
    input logic              res_valid_o,
    input logic              res_skip_o
);
    import pat_expand_pkg::*;

    logic accept;
    assign accept = req_valid_i && !busy_o;

    p_rd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    p_mono_rd_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ctl_i[CTL_MONO] && !ctl_i[CTL_SOLID]) |=>
            (mem_rd_o && ((mem_addr_o - $past(pat_base_i)) < ADDR_W'(8))));

    p_solid_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ctl_i[CTL_MONO] && ctl_i[CTL_SOLID]) |=>
            (!mem_rd_o ##1 res_valid_o));

    p_res_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    p_res_after_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_rd_o && mem_rvalid_i) |=> res_valid_o);

    p_skip_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_skip_o |-> res_valid_o);

    p_no_read_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_rd_o) |=> !mem_rd_o);

    p_read_implies_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o);

endmodule

bind pat_expand pat_expand_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .ctl_i        (ctl_i),
    .pat_base_i   (pat_base_i),
    .busy_o       (busy_o),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .res_valid_o  (res_valid_o),
    .res_skip_o   (res_skip_o)
);

// File: tb/pat_expand_test.sv
module pat_expand_test;

    localparam int ADDR_W  = 24;
    localparam int COORD_W = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid_i = 1'b0;
    logic [31:0]        ctl_i = '0;
    logic [ADDR_W-1:0]  pat_base_i = '0;
    logic [2:0]         dst_lo_i = '0;
    logic [2:0]         valign_i = '0;
    logic [COORD_W-1:0] x_i = '0;
    logic [COORD_W-1:0] y_i = '0;
    logic [31:0]        fg_i = '0;
    logic [31:0]        bg_i = '0;
    logic [1:0]         bpp_i = '0;
    logic               busy_o, mem_rd_o, mem_rvalid_i = 1'b0;
    logic [ADDR_W-1:0]  mem_addr_o;
    logic [7:0]         mem_rdata_i = '0;
    logic               res_valid_o, res_skip_o;
    logic [31:0]        res_color_o;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pat_expand #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .COLOR_BYTES(4)) uut (.*);

    task automatic chk(input logic ok, input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    logic [31:0]        r_ctl;
    logic [ADDR_W-1:0]  r_base;
    int                 r_dst, r_va, r_x, r_y, r_bpp, r_delay;
    logic [31:0]        r_fg, r_bg;

    task automatic go();
        bit mono, solid, tr, fast, pbit, eskip;
        int row, col;
        logic [ADDR_W-1:0] eaddr;
        logic [7:0]  bv;
        logic [63:0] mask;
        logic [31:0] ecol;
        string ctag, stag, atag;
        mono  = r_ctl[18];
        solid = r_ctl[19];
        tr    = r_ctl[17];
        fast  = (mono && solid) || (!mono && r_bpp != 0);
        row   = (r_va + r_y) % 8;
        col   = (r_dst + r_x) % 8;
        eaddr = mono ? r_base + ADDR_W'(row) : r_base + ADDR_W'(8 * row + col);
        bv    = fast ? 8'h00 : mem_byte(eaddr);
        mask  = (64'd1 << (8 * (r_bpp + 1))) - 64'd1;
        eskip = 1'b0;
        if (mono) begin
            pbit  = solid ? 1'b0 : bv[col];
            ecol  = (pbit ? r_fg : r_bg) & mask[31:0];
            eskip = !pbit && tr;
            ctag  = solid ? "R7" : "R4";
        end else if (r_bpp == 0) begin
            ecol = {24'h0, bv};
            ctag = "R8";
        end else begin
            ecol = r_bg & mask[31:0];
            ctag = "R9";
        end
        stag = mono ? "R5" : "R8";
        atag = mono ? "R2" : "R3";

        @(negedge clk);
        req_valid_i = 1'b1;
        ctl_i       = r_ctl;
        pat_base_i  = r_base;
        dst_lo_i    = 3'(r_dst);
        valign_i    = 3'(r_va);
        x_i         = COORD_W'(r_x);
        y_i         = COORD_W'(r_y);
        fg_i        = r_fg;
        bg_i        = r_bg;
        bpp_i       = 2'(r_bpp);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(busy_o == 1'b1, "R11 busy", 64'(busy_o), 64'd1);
        if (fast) begin
            chk(mem_rd_o == 1'b0, mono ? "R7 no read" : "R9 no read", 64'(mem_rd_o), 64'd0);
            @(negedge clk);
        end else begin
            chk(mem_rd_o == 1'b1, atag, 64'(mem_rd_o), 64'd1);
            chk(mem_addr_o == eaddr, atag, 64'(mem_addr_o), 64'(eaddr));
            repeat (r_delay) begin
                @(negedge clk);
                chk(res_valid_o == 1'b0 && mem_rd_o == 1'b0, "R10 early", 64'(res_valid_o), 64'd0);
            end
            mem_rvalid_i = 1'b1;
            mem_rdata_i  = bv;
            @(negedge clk);
            mem_rvalid_i = 1'b0;
            mem_rdata_i  = 8'h00;
        end
        chk(res_valid_o == 1'b1, "R10 valid", 64'(res_valid_o), 64'd1);
        chk(res_color_o == ecol, ctag, 64'(res_color_o), 64'(ecol));
        chk(res_skip_o == eskip, stag, 64'(res_skip_o), 64'(eskip));
        if (mono && r_bpp < 3)
            chk((64'(res_color_o) & ~mask) == 0, "R6 mask", 64'(res_color_o), 64'(ecol));
        @(negedge clk);
        chk(res_valid_o == 1'b0, "R10 pulse", 64'(res_valid_o), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && mem_rd_o == 0 && res_valid_o == 0, "R1 reset",
            {61'd0, busy_o, mem_rd_o, res_valid_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && res_valid_o == 0, "R1 idle", {62'd0, busy_o, res_valid_o}, 64'd0);

        r_fg = 32'hA1B2C3D4;
        r_bg = 32'h15263748;
        // Monochrome sweep, R2 R4 R5 R6, x and y carry high bits to test wrap.
        for (int va = 0; va < 8; va++)
            for (int y = 0; y < 8; y++)
                for (int d = 0; d < 8; d++)
                    for (int x = 0; x < 8; x++) begin
                        r_ctl   = (32'd1 << 18) | (((x + y) % 2 == 1) ? (32'd1 << 17) : 32'd0);
                        r_base  = 24'h001000 + ADDR_W'(va * 257);
                        r_va    = va;
                        r_y     = y + 8 * ((va + d) % 5);
                        r_dst   = d;
                        r_x     = x + 16 * y;
                        r_bpp   = (d + va) % 4;
                        r_delay = 1 + (x % 3);
                        go();
                    end
        // Colour one byte per pixel sweep, R3 R8 with bits 17 and 19 toggled.
        for (int va = 0; va < 8; va++)
            for (int y = 0; y < 8; y++)
                for (int d = 0; d < 8; d++)
                    for (int x = 0; x < 8; x++) begin
                        r_ctl   = ((x % 2 == 1) ? (32'd1 << 17) : 32'd0) |
                                  ((y % 2 == 1) ? (32'd1 << 19) : 32'd0);
                        r_base  = 24'h02F000 + ADDR_W'(d * 64);
                        r_va    = va;
                        r_y     = y + 24;
                        r_dst   = d;
                        r_x     = x + 40;
                        r_bpp   = 0;
                        r_delay = 1 + ((x + y) % 3);
                        go();
                    end
        // Solid fill R7 and colour wide pixels R9.
        for (int b = 0; b < 4; b++)
            for (int t = 0; t < 2; t++) begin
                r_ctl = (32'd1 << 18) | (32'd1 << 19) | (t == 1 ? (32'd1 << 17) : 32'd0);
                r_bpp = b; r_x = b; r_y = t; r_dst = 3; r_va = 5; r_delay = 1;
                go();
                r_ctl = (t == 1 ? (32'd1 << 17) : 32'd0);
                if (b != 0) go();
            end

        // R11: a request during a pending read is ignored.
        r_ctl = 32'd1 << 18; r_base = 24'h004000; r_va = 2; r_y = 3; r_dst = 1; r_x = 2;
        r_bpp = 3;
        @(negedge clk);
        req_valid_i = 1'b1; ctl_i = r_ctl; pat_base_i = r_base; valign_i = 3'd2;
        y_i = 12'd3; dst_lo_i = 3'd1; x_i = 12'd2; bpp_i = 2'd3; fg_i = r_fg; bg_i = r_bg;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(mem_addr_o == 24'h004005, "R11 first addr", 64'(mem_addr_o), 64'h4005);
        @(negedge clk);
        req_valid_i = 1'b1; ctl_i = (32'd1 << 18) | (32'd1 << 19) | (32'd1 << 17);
        pat_base_i = 24'h009000; fg_i = 32'h0; bg_i = 32'h0;
        @(negedge clk);
        chk(mem_rd_o == 1'b0 && res_valid_o == 1'b0, "R11 no action",
            {62'd0, mem_rd_o, res_valid_o}, 64'd0);
        req_valid_i = 1'b0;
        mem_rvalid_i = 1'b1; mem_rdata_i = 8'h08;
        @(negedge clk);
        mem_rvalid_i = 1'b0; mem_rdata_i = 8'h00;
        chk(res_valid_o == 1'b1 && res_color_o == r_fg && res_skip_o == 1'b0, "R11 result",
            64'(res_color_o), 64'(r_fg));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(res_valid_o == 1'b0 && mem_rd_o == 1'b0 && busy_o == 1'b0, "R11 quiet",
                {61'd0, res_valid_o, mem_rd_o, busy_o}, 64'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule